// File: doc/BRIEF.md
# Peripheral idle handshake controller

This block runs in a peripheral's system-interface clock domain and decides when the peripheral may answer a host sleep request with an idle acknowledge. A two-bit idle policy, held in a configuration register, picks the behaviour. The policies are: unconditional idle, idle refused, and two codes that both select activity-aware idle. The activity-aware policy waits until input capture is finished, no interrupt is pending, the raw interrupt status vector is all zero, and no debounce-time write is waiting to be synchronized. While the peripheral sits acknowledged, the internal clock-gate enable is dropped. It comes back, together with the withdrawal of the acknowledge, in the cycle the request falls.

The block also sequences reset. The active-low hardware reset, or a self-clearing software reset bit, clears the policy register and the state machine. It then runs a four-phase handshake with a second, slower debounce clock domain. The reset-done flag rises only after that domain has seen the reset request and both sides have let it go again.

Top module: `idle_hs_ctrl`

## Requirements
- R1: With policy code 0, a request that is high at a clock edge gives an acknowledge from that edge on, whatever the activity inputs show.
- R2: With policy code 1, the acknowledge never rises and the clock-gate enable stays high.
- R3: With policy code 2 or 3, the acknowledge rises at the first edge where the request is high and all four activity inputs are clear (capture busy 0, interrupt pending 0, raw status all zero, debounce write pending 0). Any one of them being active holds it off.
- R4: The acknowledge falls in the same cycle the request falls, with no clock edge in between.
- R5: The clock-gate enable is low exactly while the acknowledge is high.
- R6: During and after hardware reset, the policy code, the software reset bit, the reset-done flag and the acknowledge read 0, and the clock-gate enable reads 1.
- R7: A configuration write with the software reset bit at 1, made while reset-done is 1, clears the policy code to 0 and the reset-done flag to 0 from the next edge. Configuration writes are ignored while reset-done is 0.
- R8: Reset-done rises only after the debounce-domain handshake finishes: not within 2 cycles of the reset starting, and within 64 cycles.
- R9: The software reset bit reads 1 while its reset runs and clears itself by the time reset-done is 1.
- R10: Once acknowledged, the block stays acknowledged while the request stays high, even if activity resumes or the policy code changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System-interface clock |
| db_clk | input | 1 | Debounce-domain clock |
| rst_n | input | 1 | Active-low synchronous hardware reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | Idle policy code to write |
| cfg_srst | input | 1 | Software reset bit to write |
| idle_req | input | 1 | Host sleep request |
| cap_busy | input | 1 | Input capture still in progress |
| irq_pend | input | 1 | Interrupt pending to the host |
| raw_status | input | NCH | Raw interrupt status vector |
| dbt_wr_pend | input | 1 | Debounce-time write awaiting synchronization |
| idle_ack | output | 1 | Idle acknowledge |
| clk_gate_en | output | 1 | Internal clock enable (1 = run) |
| mode_q | output | 2 | Current idle policy code |
| srst_q | output | 1 | Software reset bit |
| rst_done | output | 1 | Reset completed in both domains |

## Verification
Two things can fall in the same cycle: the request dropping while the activity-aware policy would otherwise enter idle, and a policy write landing on the edge where the state machine acts on the old code. Random request, activity and policy-write patterns make both happen many times. A cycle model updated at each edge predicts the result: it takes the transition with the old policy, then applies the write, and gates the acknowledge with the live request. The directed part also has the request fall in the same cycle as an acknowledge, and issues a software reset write together with a policy write, to check that the write is dropped and the reset wins.

// File: rtl/idle_pkg.sv
// Shared types for the idle handshake controller.
// Assumes policy codes are two bits wide with both upper codes meaning smart idle.
package idle_pkg;
    typedef enum logic [1:0] {
        MODE_FORCE     = 2'd0,
        MODE_NEVER     = 2'd1,
        MODE_SMART     = 2'd2,
        MODE_SMART_ALT = 2'd3
    } idle_mode_e;

    typedef enum logic {
        PS_RUN  = 1'b0,
        PS_IDLE = 1'b1
    } pol_state_e;
endpackage

// File: rtl/idle_cdc_sync.sv
// Multi-stage level synchronizer into the domain of clk.
// Assumes d is a slow level signal; reset is synchronous and active low.
module idle_cdc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the level through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/idle_activity.sv
// Folds the activity indicators into one quiet flag for smart idle.
// Assumes all inputs are already in the interface clock domain.
module idle_activity #(
    parameter int NCH = 32
) (
    input  logic           cap_busy,
    input  logic           irq_pend,
    input  logic [NCH-1:0] raw_status,
    input  logic           dbt_wr_pend,
    output logic           quiet
);
    logic raw_clear;

    // Quiet only when every source of internal activity has stopped.
    always_comb begin
        raw_clear = ~|raw_status;
        quiet     = raw_clear & ~cap_busy & ~irq_pend & ~dbt_wr_pend;
    end
endmodule

// File: rtl/idle_rst_seq.sv
// Reset sequencer: holds a reset request after hardware reset or a software
// reset write, hands it to the debounce domain, and raises done once the
// four-phase handshake has closed. Assumes rst_n is held for several cycles
// of both clocks.
module idle_rst_seq #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic db_clk,
    input  logic rst_n,
    input  logic srst_wr,
    output logic srst_q,
    output logic done_q
);
    logic pend_q;
    logic req;
    logic db_seen;
    logic db_ack_q;
    logic ack_s;

    assign req = pend_q | srst_q;

    // Debounce side: see the request and echo it back once its flops are clear.
    idle_cdc_sync #(.STAGES(SYNC_STAGES)) u_to_db (
        .clk(db_clk), .rst_n(rst_n), .d(req), .q(db_seen)
    );

    // Debounce-domain acknowledge register.
    always_ff @(posedge db_clk) begin
        if (!rst_n) db_ack_q <= 1'b0;
        else        db_ack_q <= db_seen;
    end

    idle_cdc_sync #(.STAGES(SYNC_STAGES)) u_to_if (
        .clk(clk), .rst_n(rst_n), .d(db_ack_q), .q(ack_s)
    );

    // Interface side: raise, drop and wait out the request, then flag done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b1;
            srst_q <= 1'b0;
            done_q <= 1'b0;
        end else if (srst_wr) begin
            srst_q <= 1'b1;
            done_q <= 1'b0;
        end else begin
            if (req && ack_s) begin
                pend_q <= 1'b0;
                srst_q <= 1'b0;
            end
            done_q <= ~req & ~ack_s;
        end
    end
endmodule

// File: rtl/idle_policy_fsm.sv
// Idle policy state machine: decides entry to idle per policy code and drives
// the acknowledge and clock-gate enable. Assumes run_en is low while reset runs.
module idle_policy_fsm
    import idle_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_en,
    input  idle_mode_e mode,
    input  logic       req,
    input  logic       quiet,
    output logic       ack,
    output logic       gate_en
);
    pol_state_e state_q;
    pol_state_e state_d;
    logic       may_enter;

    // Entry condition for the current policy.
    always_comb begin
        unique case (mode)
            MODE_FORCE:                 may_enter = 1'b1;
            MODE_NEVER:                 may_enter = 1'b0;
            MODE_SMART, MODE_SMART_ALT: may_enter = quiet;
            default:                    may_enter = 1'b0;
        endcase
    end

    // Next state: enter on request, leave as soon as the request drops.
    always_comb begin
        state_d = state_q;
        if (state_q == PS_RUN) begin
            if (req && may_enter) state_d = PS_IDLE;
        end else if (!req) begin
            state_d = PS_RUN;
        end
    end

    // State register, held in RUN while reset sequencing is active.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_en) state_q <= PS_RUN;
        else                   state_q <= state_d;
    end

    // Acknowledge falls with the request in the same cycle.
    always_comb begin
        ack     = (state_q == PS_IDLE) & req & run_en;
        gate_en = ~ack;
    end
endmodule

// File: rtl/idle_hs_ctrl.sv
// Top of the idle handshake controller: policy register, activity folding,
// reset sequencing and the policy state machine.
// Assumes all inputs except db_clk are synchronous to clk.
module idle_hs_ctrl
    import idle_pkg::*;
#(
    parameter int NCH         = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           db_clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [1:0]     cfg_mode,
    input  logic           cfg_srst,
    input  logic           idle_req,
    input  logic           cap_busy,
    input  logic           irq_pend,
    input  logic [NCH-1:0] raw_status,
    input  logic           dbt_wr_pend,
    output logic           idle_ack,
    output logic           clk_gate_en,
    output logic [1:0]     mode_q,
    output logic           srst_q,
    output logic           rst_done
);
    idle_mode_e mode_r;
    logic       srst_wr;
    logic       quiet;

    assign srst_wr = cfg_we & cfg_srst & rst_done;

    // Policy register: cleared by reset, writes accepted only when done.
    always_ff @(posedge clk) begin
        if (!rst_n || !rst_done || srst_wr) mode_r <= MODE_FORCE;
        else if (cfg_we)                    mode_r <= idle_mode_e'(cfg_mode);
    end

    assign mode_q = mode_r;

    idle_activity #(.NCH(NCH)) u_act (
        .cap_busy(cap_busy), .irq_pend(irq_pend), .raw_status(raw_status),
        .dbt_wr_pend(dbt_wr_pend), .quiet(quiet)
    );

    idle_rst_seq #(.SYNC_STAGES(SYNC_STAGES)) u_rst (
        .clk(clk), .db_clk(db_clk), .rst_n(rst_n), .srst_wr(srst_wr),
        .srst_q(srst_q), .done_q(rst_done)
    );

    idle_policy_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .run_en(rst_done), .mode(mode_r),
        .req(idle_req), .quiet(quiet), .ack(idle_ack), .gate_en(clk_gate_en)
    );
endmodule

// File: rtl/idle_hs_ctrl_chk.sv
// Port-level checker for the idle handshake controller, bound to the top.
module idle_hs_ctrl_chk #(
    parameter int NCH = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cfg_we,
    input logic           cfg_srst,
    input logic           idle_req,
    input logic           cap_busy,
    input logic           irq_pend,
    input logic [NCH-1:0] raw_status,
    input logic           dbt_wr_pend,
    input logic           idle_ack,
    input logic           clk_gate_en,
    input logic [1:0]     mode_q,
    input logic           srst_q,
    input logic           rst_done
);
    logic quiet_obs;
    assign quiet_obs = !cap_busy && !irq_pend && (raw_status == '0) && !dbt_wr_pend;

    a_r1_force_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_done && mode_q == 2'd0 && idle_req && !cfg_we) |=> (idle_ack || !idle_req));
    a_r2_never_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_ack) |-> $past(mode_q) != 2'd1);
    a_r3_smart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(idle_ack) && $past(mode_q[1])) |-> $past(quiet_obs));
    a_r4_ack_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_req |-> !idle_ack);
    a_r5_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
        idle_ack |-> !clk_gate_en);
    a_r5_gate_on: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_ack |-> clk_gate_en);
    a_r6_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_done |-> mode_q == 2'd0);
    a_r7_srst_start: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_done && cfg_we && cfg_srst) |=> (!rst_done && srst_q && mode_q == 2'd0));
    a_r9_srst_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rst_done |-> !srst_q);
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(idle_ack) && idle_req && rst_done) |-> idle_ack);
endmodule

bind idle_hs_ctrl idle_hs_ctrl_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_srst(cfg_srst),
    .idle_req(idle_req), .cap_busy(cap_busy), .irq_pend(irq_pend),
    .raw_status(raw_status), .dbt_wr_pend(dbt_wr_pend), .idle_ack(idle_ack),
    .clk_gate_en(clk_gate_en), .mode_q(mode_q), .srst_q(srst_q), .rst_done(rst_done)
);

// File: tb/idle_hs_ctrl_test.sv
`timescale 1ns/1ps
module idle_hs_ctrl_test;
    localparam int NCH = 32;

    logic           clk = 1'b0;
    logic           db_clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cfg_we = 1'b0;
    logic [1:0]     cfg_mode = 2'd0;
    logic           cfg_srst = 1'b0;
    logic           idle_req = 1'b0;
    logic           cap_busy = 1'b0;
    logic           irq_pend = 1'b0;
    logic [NCH-1:0] raw_status = '0;
    logic           dbt_wr_pend = 1'b0;
    logic           idle_ack, clk_gate_en, srst_q, rst_done;
    logic [1:0]     mode_q;

    int checks = 0;
    int errors = 0;
    bit m_idle = 1'b0;
    bit m_done = 1'b0;
    logic [1:0] m_mode = 2'd0;
    int since_rst = 0;

    always #2.5 clk = ~clk;
    always #3.5 db_clk = ~db_clk;

    idle_hs_ctrl #(.NCH(NCH)) uut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit quiet_now();
        return !cap_busy && !irq_pend && raw_status == '0 && !dbt_wr_pend;
    endfunction

    function automatic string mode_tag(input logic [1:0] m);
        return (m == 2'd0) ? "R1" : (m == 2'd1) ? "R2" : "R3";
    endfunction

    // One clock: update model at the edge, compare at the following negedge.
    task automatic step();
        @(posedge clk);
        if (m_done && cfg_we && cfg_srst) begin
            m_done = 1'b0; m_mode = 2'd0; m_idle = 1'b0; since_rst = 0;
        end else if (!m_done) begin
            m_mode = 2'd0; m_idle = 1'b0;
        end else begin
            if (m_idle) m_idle = idle_req;
            else if (idle_req && (m_mode == 2'd0 || (m_mode[1] && quiet_now()))) m_idle = 1'b1;
            if (cfg_we) m_mode = cfg_mode;
        end
        @(negedge clk);
        if (!m_done) begin
            since_rst++;
            if (rst_done) begin
                m_done = 1'b1;
                chk(since_rst > 2 && since_rst <= 64, "R8", since_rst, 64);
                chk(srst_q == 1'b0, "R9", srst_q, 0);
            end
        end
        chk(idle_ack == (m_idle && idle_req && m_done),
            m_idle ? "R10" : mode_tag(m_mode), idle_ack, m_idle && idle_req && m_done);
        chk(clk_gate_en == !idle_ack, "R5", clk_gate_en, !idle_ack);
        chk(mode_q == m_mode, "R7", mode_q, m_mode);
    endtask

    task automatic wait_done();
        for (int i = 0; i < 80 && !m_done; i++) step();
        chk(m_done, "R8", rst_done, 1);
    endtask

    task automatic set_mode(input logic [1:0] m);
        cfg_we = 1'b1; cfg_mode = m; cfg_srst = 1'b0;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic clear_act();
        cap_busy = 0; irq_pend = 0; raw_status = '0; dbt_wr_pend = 0;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d1e5eed));
        // R6: reset state
        repeat (8) @(negedge clk);
        chk(mode_q == 0 && srst_q == 0 && rst_done == 0, "R6", {mode_q, srst_q, rst_done}, 0);
        chk(idle_ack == 0 && clk_gate_en == 1, "R6", {idle_ack, clk_gate_en}, 1);
        rst_n = 1'b1;
        since_rst = 0;
        wait_done();

        // R1: force idle while every activity input is busy
        cap_busy = 1; irq_pend = 1; raw_status = 32'h8000_0001; dbt_wr_pend = 1;
        idle_req = 1;
        step();
        chk(idle_ack == 1 && clk_gate_en == 0, "R1", idle_ack, 1);
        // R4: request drops, ack and gate enable follow in the same cycle
        idle_req = 0;
        #1;
        chk(idle_ack == 0 && clk_gate_en == 1, "R4", idle_ack, 0);
        step();

        // R2: never idle
        set_mode(2'd1);
        clear_act(); idle_req = 1;
        repeat (5) step();
        chk(idle_ack == 0 && clk_gate_en == 1, "R2", idle_ack, 0);
        idle_req = 0; step();

        // R3: each activity source alone blocks smart idle
        set_mode(2'd3);
        for (int k = 0; k < 4; k++) begin
            clear_act();
            case (k)
                0: cap_busy = 1;
                1: irq_pend = 1;
                2: raw_status = 32'h0001_0000;
                default: dbt_wr_pend = 1;
            endcase
            idle_req = 1;
            repeat (3) step();
            chk(idle_ack == 0, "R3", idle_ack, 0);
            clear_act();
            step();
            chk(idle_ack == 1, "R3", idle_ack, 1);
            // R10: activity returns and the policy changes, ack holds
            cap_busy = 1;
            cfg_we = 1; cfg_mode = 2'd1;
            step();
            cfg_we = 0;
            step();
            chk(idle_ack == 1, "R10", idle_ack, 1);
            idle_req = 0; clear_act(); step();
            set_mode(2'd2);
        end

        // R7/R9: software reset together with a policy write
        cfg_we = 1; cfg_srst = 1; cfg_mode = 2'd2;
        step();
        cfg_we = 0; cfg_srst = 0;
        chk(rst_done == 0 && srst_q == 1, "R9", {rst_done, srst_q}, 1);
        chk(mode_q == 0, "R7", mode_q, 0);
        cfg_we = 1; cfg_mode = 2'd3;      // ignored while not done
        step();
        cfg_we = 0;
        chk(mode_q == 0, "R7", mode_q, 0);
        wait_done();

        // Random phase with mixed policy writes and activity
        for (int n = 0; n < 3000; n++) begin
            idle_req    = ($urandom_range(0, 3) != 0);
            cap_busy    = ($urandom_range(0, 3) == 0);
            irq_pend    = ($urandom_range(0, 3) == 0);
            dbt_wr_pend = ($urandom_range(0, 3) == 0);
            raw_status  = ($urandom_range(0, 3) == 0) ? NCH'(1) << $urandom_range(0, NCH-1) : '0;
            cfg_we      = ($urandom_range(0, 15) == 0);
            cfg_mode    = 2'($urandom_range(0, 3));
            cfg_srst    = cfg_we && ($urandom_range(0, 15) == 0);
            step();
        end
        cfg_we = 0; cfg_srst = 0;
        wait_done();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule